// File: doc/BRIEF.md
# Core Voltage and Clock Step Sequencer

This block steps a core supply and its CPU clock between a low operating point and a high operating point in response to single-cycle "go fast" and "go slow" requests. It turns a millivolt setpoint into a 5-bit regulator code and places that code into three target fields of one regulator control word. It then holds itself busy for a settling time that depends on how far, and in which direction, the code moved.

Frequencies and voltages come from two small tables indexed by a 2-bit speed grade. The high point follows the grade and the low point is always table entry 0. To speed up, the block raises the voltage first and switches the clock afterwards. To slow down, it drops the clock first and lowers the voltage afterwards. Settling time is measured in microsecond ticks divided down from the system clock. The first voltage update after reset always waits a fixed worst-case time, because the supply state is unknown at that point.

Top module: `dvfs_seq`

## Requirements
- R1: A millivolt setpoint maps to code 0 when it is below 725, to code 31 when it is above 1450, and otherwise to (mV − 700) / 25 rounded down. For example, 724 gives 0, 1450 gives 30 and 1500 gives 31.
- R2: `core_mv` always reports code × 25 + 700. After reset the code is 0, so `core_mv` is 700 and `clk_mhz` is table entry 0 (792).
- R3: The code sits in bits [4:0], [13:9] and [22:18] of `ctrl_word`, and all three fields always hold the same value. Every other bit keeps the `RESET_WORD` value at all times.
- R4: Once the first update has been made, a request whose target code equals the present code leaves `ctrl_word` unwritten and adds no wait. `done` pulses 2 clock edges after the edge that samples the request.
- R5: Raising the code waits `US_PER_STEP` (3) µs per code step, each µs being `TICK_DIV` clocks. A go-fast that raises by k codes pulses `done` 2 + 3·k·`TICK_DIV` edges after the sampling edge. Lowering the code adds no wait: a go-slow pulses `done` after 3 edges.
- R6: The first update after reset waits 28 × 3 = 84 µs whatever its direction. `done` pulses 2 + 84·`TICK_DIV` edges after the sampling edge.
- R7: Speed grades 0 to 3 select the high point from the frequency table 792/852/996/1200 MHz and the voltage table 1150/1225/1225/1275 mV. Going fast sets the high point of the grade sampled with the request. Going slow always sets entry 0.
- R8: On a go-fast, `ctrl_word` takes its new code in an earlier cycle than `clk_mhz` takes its new value. On a go-slow, `clk_mhz` changes first. The two outputs never change in the same cycle.
- R9: A go-fast is ignored (no `busy`, no `done`, no output change) when `clk_mhz` is not below the grade's high frequency. A go-slow is ignored when `clk_mhz` is not above entry 0.
- R10: `busy` is high from the cycle after an accepted request until `done` pulses, and requests arriving while `busy` is high are ignored. `done` is a one-cycle pulse with `busy` low.
- R11: When `go_fast` and `go_slow` are sampled high together, the go-fast is carried out and the go-slow is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| speed_grade | input | 2 | Index of the high operating point |
| go_fast | input | 1 | Request to move to the high point |
| go_slow | input | 1 | Request to move to the low point |
| ctrl_word | output | 32 | Regulator control word with three code fields |
| clk_mhz | output | 16 | Requested CPU clock in MHz |
| core_mv | output | 16 | Present core voltage in millivolts |
| busy | output | 1 | A step is in progress |
| done | output | 1 | One-cycle pulse when a step completes |

## Verification
The ordering and field properties assume the voltage table does not decrease with grade, so that a go-fast never needs to lower the code. The stimulus uses the ascending default table and a second instance whose table is reordered only to reach the clamp points. Requests are one-cycle pulses, and the speed grade changes only while the block is idle, except for one deliberate request made during a busy step. The pass/fail judgement of each step comes from its latency, counted from the sampling edge to the `done` pulse, and from the final clock, millivolt and control-word values.

// File: rtl/dvfs_pkg.sv
`timescale 1ns/1ps
package dvfs_pkg;
    localparam int CODE_W   = 5;
    localparam int VAL_W    = 16;
    localparam int WORD_W   = 32;
    localparam int N_FIELDS = 3;
    localparam int unsigned FIELD_LSB [N_FIELDS] = '{0, 9, 18};
    localparam int MV_BASE  = 700;
    localparam int MV_STEP  = 25;
    localparam int MV_LO    = 725;
    localparam int MV_HI    = 1450;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [VAL_W-1:0]  val_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLK_DOWN,
        ST_VOLT,
        ST_SETTLE,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic  raise;
        code_t code;
        val_t  mhz;
    } step_t;

    function automatic code_t mv_to_code(input val_t mv);
        if (mv < val_t'(MV_LO))
            return '0;
        else if (mv > val_t'(MV_HI))
            return '1;
        else
            return code_t'((mv - val_t'(MV_BASE)) / val_t'(MV_STEP));
    endfunction

    function automatic val_t code_to_mv(input code_t c);
        return val_t'(c) * val_t'(MV_STEP) + val_t'(MV_BASE);
    endfunction

    function automatic val_t tab_pick(input logic [4*VAL_W-1:0] tab, input logic [1:0] idx);
        return tab[idx*VAL_W +: VAL_W];
    endfunction

    function automatic word_t field_mask();
        word_t m;
        m = '0;
        for (int k = 0; k < N_FIELDS; k++)
            m = m | (word_t'({CODE_W{1'b1}}) << FIELD_LSB[k]);
        return m;
    endfunction
endpackage

// File: rtl/dvfs_settle_timer.sv
`timescale 1ns/1ps
module dvfs_settle_timer #(
    parameter int TICK_DIV = 250,
    parameter int US_W     = 7
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [US_W-1:0] us_in,
    output logic            expired
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_q;
    logic [US_W-1:0]  us_left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q     <= '0;
            us_left_q <= '0;
        end else if (load) begin
            pre_q     <= PRE_TOP;
            us_left_q <= us_in;
        end else if (us_left_q != '0) begin
            if (pre_q == '0) begin
                pre_q     <= PRE_TOP;
                us_left_q <= us_left_q - 1'b1;
            end else begin
                pre_q <= pre_q - 1'b1;
            end
        end
    end

    assign expired = (us_left_q == US_W'(1)) && (pre_q == '0);
endmodule

// File: rtl/dvfs_ctrl_word.sv
`timescale 1ns/1ps
module dvfs_ctrl_word
    import dvfs_pkg::*;
#(
    parameter word_t RESET_WORD = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  code_t code,
    output word_t word
);
    localparam word_t MASK = field_mask();

    word_t field_val [N_FIELDS];
    word_t merged;
    word_t word_q;

    for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
        assign field_val[g] = word_t'(code) << FIELD_LSB[g];
    end

    always_comb begin
        merged = word_q & ~MASK;
        for (int k = 0; k < N_FIELDS; k++)
            merged = merged | field_val[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= RESET_WORD & ~MASK;
        else if (wr_en)
            word_q <= merged;
    end

    assign word = word_q;
endmodule

// File: rtl/dvfs_seq.sv
`timescale 1ns/1ps
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int                   TICK_DIV    = 250,
    parameter int                   US_PER_STEP = 3,
    parameter int                   FIRST_STEPS = 28,
    parameter logic [4*VAL_W-1:0]   MHZ_TAB     = {16'd1200, 16'd996, 16'd852, 16'd792},
    parameter logic [4*VAL_W-1:0]   MV_TAB      = {16'd1275, 16'd1225, 16'd1225, 16'd1150},
    parameter logic [WORD_W-1:0]    RESET_WORD  = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  speed_grade,
    input  logic        go_fast,
    input  logic        go_slow,
    output logic [31:0] ctrl_word,
    output logic [15:0] clk_mhz,
    output logic [15:0] core_mv,
    output logic        busy,
    output logic        done
);
    localparam int FIRST_US = FIRST_STEPS * US_PER_STEP;
    localparam int STEP_US  = ((1 << CODE_W) - 1) * US_PER_STEP;
    localparam int MAX_US   = (FIRST_US > STEP_US) ? FIRST_US : STEP_US;
    localparam int US_W     = $clog2(MAX_US + 1);

    seq_state_e  state_q;
    step_t       step_q;
    code_t       cur_code_q;
    logic        first_done_q;
    val_t        clk_mhz_q;
    logic        done_q;

    val_t        hi_mhz, lo_mhz;
    code_t       hi_code, lo_code;
    logic        fast_ok, slow_ok;
    logic        same_code;
    logic [US_W-1:0] wait_us;
    logic        wr_en, tmr_load, tmr_expired;

    assign hi_mhz  = tab_pick(MHZ_TAB, speed_grade);
    assign lo_mhz  = tab_pick(MHZ_TAB, 2'd0);
    assign hi_code = mv_to_code(tab_pick(MV_TAB, speed_grade));
    assign lo_code = mv_to_code(tab_pick(MV_TAB, 2'd0));

    assign fast_ok = go_fast && (clk_mhz_q < hi_mhz);
    assign slow_ok = go_slow && !go_fast && (clk_mhz_q > lo_mhz);

    always_comb begin
        same_code = first_done_q && (step_q.code == cur_code_q);
        if (!first_done_q)
            wait_us = US_W'(FIRST_US);
        else if (step_q.code > cur_code_q)
            wait_us = US_W'(step_q.code - cur_code_q) * US_W'(US_PER_STEP);
        else
            wait_us = '0;
    end

    assign wr_en    = (state_q == ST_VOLT) && !same_code;
    assign tmr_load = wr_en && (wait_us != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            step_q       <= '0;
            cur_code_q   <= '0;
            first_done_q <= 1'b0;
            clk_mhz_q    <= tab_pick(MHZ_TAB, 2'd0);
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (fast_ok) begin
                        step_q  <= '{raise: 1'b1, code: hi_code, mhz: hi_mhz};
                        state_q <= ST_VOLT;
                    end else if (slow_ok) begin
                        step_q  <= '{raise: 1'b0, code: lo_code, mhz: lo_mhz};
                        state_q <= ST_CLK_DOWN;
                    end
                end
                ST_CLK_DOWN: begin
                    clk_mhz_q <= step_q.mhz;
                    state_q   <= ST_VOLT;
                end
                ST_VOLT: begin
                    if (!same_code) begin
                        cur_code_q   <= step_q.code;
                        first_done_q <= 1'b1;
                    end
                    state_q <= tmr_load ? ST_SETTLE : ST_FINISH;
                end
                ST_SETTLE: begin
                    if (tmr_expired)
                        state_q <= ST_FINISH;
                end
                ST_FINISH: begin
                    if (step_q.raise)
                        clk_mhz_q <= step_q.mhz;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    dvfs_settle_timer #(
        .TICK_DIV (TICK_DIV),
        .US_W     (US_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .us_in   (wait_us),
        .expired (tmr_expired)
    );

    dvfs_ctrl_word #(
        .RESET_WORD (RESET_WORD)
    ) u_word (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .code  (step_q.code),
        .word  (ctrl_word)
    );

    assign clk_mhz = clk_mhz_q;
    assign core_mv = code_to_mv(cur_code_q);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
endmodule

// File: rtl/dvfs_seq_checker.sv
`timescale 1ns/1ps
module dvfs_seq_checker
    import dvfs_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_word,
    input logic [15:0] clk_mhz,
    input logic [15:0] core_mv,
    input logic        busy,
    input logic        done
);
    localparam word_t MASK = field_mask();

    code_t f0, f1, f2;
    assign f0 = ctrl_word[FIELD_LSB[0] +: CODE_W];
    assign f1 = ctrl_word[FIELD_LSB[1] +: CODE_W];
    assign f2 = ctrl_word[FIELD_LSB[2] +: CODE_W];

    // R3: all three target fields carry one code
    p_fields_match_r3: assert property (@(posedge clk) disable iff (rst)
        (f0 == f1) && (f1 == f2));

    // R3: bits outside the fields never move
    p_other_bits_hold_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(ctrl_word & ~MASK));

    // R2: reported voltage follows the code in the control word
    p_mv_tracks_code_r2: assert property (@(posedge clk) disable iff (rst)
        core_mv == code_to_mv(f0));

    // R8: clock and voltage never change in the same cycle
    p_volt_clk_apart_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_mhz) |-> $stable(ctrl_word));

    // R10: completion is a single pulse outside the busy window
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind dvfs_seq dvfs_seq_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_word (ctrl_word),
    .clk_mhz   (clk_mhz),
    .core_mv   (core_mv),
    .busy      (busy),
    .done      (done)
);

// File: tb/dvfs_seq_bench.sv
`timescale 1ns/1ps
module dvfs_seq_bench;
    localparam int          TDIV  = 8;
    localparam logic [31:0] BASE  = 32'hA5A5_A5A5;
    localparam logic [31:0] FMASK = 32'h007C_3E1F;

    // columns: grade, fast, slow, exp_mhz, exp_mv, exp_latency (0 = ignored), req tag
    localparam int MAIN_N = 10;
    localparam int MAIN_VEC [MAIN_N][7] = '{
        '{1, 1, 0,  852, 1225, 674, 6},   // R6 first update, fixed wait
        '{1, 0, 1,  792, 1150,   3, 5},   // R5 lowering, no wait
        '{2, 1, 0,  996, 1225,  74, 5},   // R5 raise by 3 codes
        '{1, 1, 0,  996, 1225,   0, 9},   // R9 not below grade maximum
        '{3, 1, 0, 1200, 1275,  50, 7},   // R7 grade 3 point
        '{0, 0, 1,  792, 1150,   3, 8},   // R8 slow ordering
        '{0, 0, 1,  792, 1150,   0, 9},   // R9 already at minimum
        '{0, 1, 0,  792, 1150,   0, 9},   // R9 grade 0 max equals min
        '{1, 1, 0,  852, 1225,  74, 7},   // R7 grade 1 point
        '{2, 1, 0,  996, 1225,   2, 4}    // R4 equal code, no write
    };
    localparam int CLAMP_N = 5;
    localparam int CLAMP_VEC [CLAMP_N][7] = '{
        '{1, 1, 0,  852, 1475, 674, 1},   // R1 1500 mV clamps to 31
        '{1, 0, 1,  792,  700,   3, 1},   // R1 700 mV gives 0
        '{3, 1, 0, 1200, 1450, 722, 1},   // R1 1450 mV gives 30
        '{0, 0, 1,  792,  700,   3, 1},
        '{2, 1, 0,  996,  700,   2, 1}    // R1 724 mV gives 0
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] grade = '0, c_grade = '0;
    logic fast = 1'b0, slow = 1'b0, c_fast = 1'b0, c_slow = 1'b0;
    logic [31:0] ctrl_word, c_ctrl_word;
    logic [15:0] clk_mhz, core_mv, c_clk_mhz, c_core_mv;
    logic busy, done, c_busy, c_done;
    logic sel = 1'b0;
    logic [31:0] o_ctrl;
    logic [15:0] o_mhz, o_mv;
    logic o_busy, o_done;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dvfs_seq #(.TICK_DIV(TDIV), .RESET_WORD(BASE)) u_dvfs_seq (
        .clk(clk), .rst(rst), .speed_grade(grade), .go_fast(fast), .go_slow(slow),
        .ctrl_word(ctrl_word), .clk_mhz(clk_mhz), .core_mv(core_mv),
        .busy(busy), .done(done));

    dvfs_seq #(.TICK_DIV(TDIV), .RESET_WORD(BASE),
               .MV_TAB({16'd1450, 16'd724, 16'd1500, 16'd700})) u_clamp (
        .clk(clk), .rst(rst), .speed_grade(c_grade), .go_fast(c_fast), .go_slow(c_slow),
        .ctrl_word(c_ctrl_word), .clk_mhz(c_clk_mhz), .core_mv(c_core_mv),
        .busy(c_busy), .done(c_done));

    always_comb begin
        o_ctrl = sel ? c_ctrl_word : ctrl_word;
        o_mhz  = sel ? c_clk_mhz   : clk_mhz;
        o_mv   = sel ? c_core_mv   : core_mv;
        o_busy = sel ? c_busy      : busy;
        o_done = sel ? c_done      : done;
    end

    function automatic logic [31:0] exp_word(input int mv);
        logic [31:0] c;
        c = 32'((mv - 700) / 25);
        return (BASE & ~FMASK) | c | (c << 9) | (c << 18);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_op(input int g, input bit f, input bit s,
                          output int lat, output bit order_ok);
        int start_mhz, start_code, prev_mhz, prev_code, code_at_clk, mhz_at_code;
        bit saw_busy;
        @(negedge clk);
        if (sel) begin c_grade = 2'(g); c_fast = f; c_slow = s; end
        else     begin grade   = 2'(g); fast   = f; slow   = s; end
        @(posedge clk); #1;
        c_fast = 1'b0; c_slow = 1'b0; fast = 1'b0; slow = 1'b0;
        start_mhz = int'(o_mhz); start_code = int'(o_ctrl[4:0]);
        prev_mhz = start_mhz; prev_code = start_code;
        code_at_clk = -1; mhz_at_code = -1;
        lat = 0; saw_busy = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk); #1;
            if (o_busy) saw_busy = 1'b1;
            if (int'(o_mhz) != prev_mhz) code_at_clk = int'(o_ctrl[4:0]);
            if (int'(o_ctrl[4:0]) != prev_code) mhz_at_code = int'(o_mhz);
            prev_mhz = int'(o_mhz); prev_code = int'(o_ctrl[4:0]);
            if (o_done) begin lat = i + 1; break; end
            if (i >= 20 && !saw_busy) break;
        end
        if (f)
            order_ok = (code_at_clk == -1) || (code_at_clk == int'(o_ctrl[4:0]));
        else
            order_ok = (mhz_at_code == -1) || (mhz_at_code == int'(o_mhz));
    endtask

    task automatic walk(input int row, input int v [7]);
        int lat;
        bit ok;
        string tag;
        run_op(v[0], v[1] != 0, v[2] != 0, lat, ok);
        tag = $sformatf("R%0d", v[6]);
        chk(tag, $sformatf("row %0d clk_mhz", row), int'(o_mhz), v[3]);
        chk(tag, $sformatf("row %0d core_mv", row), int'(o_mv), v[4]);
        chk(tag, $sformatf("row %0d latency", row), lat, v[5]);
        checks++;
        if (o_ctrl !== exp_word(v[4])) begin
            failures++;
            $display("FAIL R3 row %0d ctrl_word actual=%h expected=%h", row, o_ctrl, exp_word(v[4]));
        end
        chk("R8", $sformatf("row %0d ordering ok", row), int'(ok), 1);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        bit ok, saw;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk("R2", "reset clk_mhz", int'(clk_mhz), 792);
        chk("R2", "reset core_mv", int'(core_mv), 700);
        chk("R3", "reset ctrl_word", int'(ctrl_word == (BASE & ~FMASK)), 1);
        chk("R10", "reset busy", int'(busy), 0);
        chk("R2", "clamp reset core_mv", int'(c_core_mv), 700);

        for (int r = 0; r < MAIN_N; r++) walk(r, MAIN_VEC[r]);

        // R10 request during busy is ignored
        @(negedge clk); grade = 2'd0; slow = 1'b1;
        @(posedge clk); #1 slow = 1'b0;
        @(negedge clk); grade = 2'd3; fast = 1'b1;
        @(posedge clk); #1 fast = 1'b0;
        lat = 0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); #1;
            if (done) begin lat = i + 2; break; end
        end
        chk("R10", "slow latency with busy request", lat, 3);
        saw = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk); #1;
            if (busy) saw = 1'b1;
        end
        chk("R10", "no second step after busy request", int'(saw), 0);
        chk("R10", "clk_mhz after ignored request", int'(clk_mhz), 792);
        chk("R10", "core_mv after ignored request", int'(core_mv), 1150);

        // R11 both requests together: fast wins, 18 -> 23 is 15 us
        run_op(3, 1'b1, 1'b1, lat, ok);
        chk("R11", "both requests clk_mhz", int'(clk_mhz), 1200);
        chk("R11", "both requests core_mv", int'(core_mv), 1275);
        chk("R11", "both requests latency", lat, 2 + 15 * TDIV);

        sel = 1'b1;
        for (int r = 0; r < CLAMP_N; r++) walk(r, CLAMP_VEC[r]);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule